// File: doc/BRIEF.md
# Nested Priority Interrupt Entry Controller

This block decides when a processor core is to be interrupted and runs the save and restore traffic that goes with it. Each of a set of request lines carries a 5-bit priority. A separate non-maskable request is also provided. The controller keeps one current mask level. It takes the highest-priority request that lies strictly above that level.

On entry it does four things:
- It chooses an interrupt frame.
- It writes a record of the interrupted control state to memory.
- It raises the mask to the level being serviced.
- It gives the core a vector number together with a one-cycle start pulse.

On return it reads the record back and restores the mask, the interrupted flag and the trace enable. It then tells the core whether the exit left the outermost interrupt.

The core supplies its current frame pointer and its arithmetic-control word. A single-ported memory interface carries the record, and its read data arrives one cycle after the read strobe. The controller owns the process-control state: mask level, interrupted flag and trace enable. That state is packed into a saved word with a fixed layout.

Top module: `irq_entry_ctrl`

## Requirements
- R1: Reset behaviour. After reset the mask level is 0, the interrupted flag is 0 and trace is disabled. No start, return-done or memory strobe is active.
- R2: Masking. A maskable request whose priority is less than or equal to the current mask level is never taken, so a priority-0 request is never taken. An ignored request causes no memory write, and it does not change the mask.
- R3: Selection among maskable requests. The highest priority above the mask wins, and on equal priority the lowest line index wins. The vector number output is that line index.
- R4: Non-maskable requests. The non-maskable request is taken at any mask level, including 31, and it wins over all maskable requests. Its vector number is NREQ, and it raises the mask to 31.
- R5: Frame selection on entry. If the interrupted flag is 0, the record base is the STACK_BASE parameter and the core's frame pointer is not used. If the flag is 1, the record base is the core's current frame pointer. The new frame pointer handed to the core is base + 16.
- R6: Record writes. An entry writes two words: the saved process-control word at base, then the core's arithmetic-control word at base + 4.
  - Saved word layout: bit 0 holds trace enable, bit 1 holds the interrupted flag, and bits 20:16 hold the mask level. All other bits are 0.
- R7: Entry timing and state. When a request is sampled at a clock edge in the idle state, the start pulse is high for exactly one cycle, beginning after the third clock edge. During that cycle the mask equals the taken level, the interrupted flag is 1 and trace is disabled. The return-status output reads 3'b111.
- R8: Return sequence. A return pulse in the idle state reads the core frame pointer − 16 and then the frame pointer − 12. Return-done is high for one cycle after the fourth clock edge. The arithmetic-control output then holds the second word read, and mask, interrupted flag and trace are restored from the fields of the first word.
- R9: Outermost exit. Outermost-exit is raised together with return-done exactly when the restored interrupted flag is 0.
- R10: Arbitration between sequences. A return pulse sampled together with a request in the idle state is served first. A return pulse that arrives while a sequence is running is dropped. Memory reads and writes are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NREQ | Maskable request lines, level sensitive |
| irq_prio | input | NREQ*5 | Priority of each line, line i at bits 5i+4:5i |
| nmi_req | input | 1 | Non-maskable request |
| ret_req | input | 1 | One-cycle pulse: the core executes an interrupt return |
| cur_fp | input | ADDR_W | Core's current frame pointer |
| ac_in | input | DATA_W | Core's arithmetic-control word |
| mem_we | output | 1 | Record write strobe |
| mem_re | output | 1 | Record read strobe |
| mem_addr | output | ADDR_W | Record byte address |
| mem_wdata | output | DATA_W | Record write data |
| mem_rdata | input | DATA_W | Read data, one cycle after mem_re |
| hstart | output | 1 | One-cycle handler start pulse |
| hvec | output | $clog2(NREQ+1) | Vector number, valid with hstart |
| new_fp | output | ADDR_W | New frame pointer, valid with hstart |
| ret_stat | output | 3 | Return-status code, 3'b111 with hstart and 0 otherwise |
| mask_lvl | output | 5 | Current mask level |
| intr_state | output | 1 | Interrupted flag |
| trace_en | output | 1 | Trace enable |
| ret_done | output | 1 | One-cycle pulse at the end of a return |
| ac_out | output | DATA_W | Restored arithmetic-control word, valid with ret_done |
| outer_exit | output | 1 | Return left the outermost interrupt |

## Verification
The bench tests a request level equal to the mask and a priority tie between two lines. A controller that compares with greater-or-equal would re-enter at the same level, and one that favours high indices would give the wrong vector. It also checks that nested entries build on the core frame pointer, while first entries ignore a deliberately bogus frame pointer. A controller that switches frames at the wrong time would write the record to the wrong address. Return and request are offered together, and a return is also pulsed in the middle of an entry. An unarbitrated design would show write strobes inside a return or a stray read. The bench unwinds random nested entries, including repeated non-maskable ones at level 31. Only the last return may raise outermost-exit, so a controller that lost the interrupted flag in the record would raise it early or never.

// File: rtl/irq_entry_pkg.sv
// Shared constants, sequencer state type and the saved control-word layout
// for the nested interrupt entry controller.
package irq_entry_pkg;
    localparam int LVL_W       = 5;
    localparam int PC_W        = 32;
    localparam int PC_TR_BIT   = 0;
    localparam int PC_ST_BIT   = 1;
    localparam int PC_MASK_LSB = 16;
    localparam logic [LVL_W-1:0] LVL_MAX = '1;
    localparam logic [2:0] RS_INTR = 3'b111;

    typedef enum logic [2:0] {
        ST_IDLE, ST_EW0, ST_EW1, ST_EDONE,
        ST_RR0, ST_RR1, ST_RR2, ST_RDONE
    } seq_t;

    // Pack mask, interrupted flag and trace enable into the saved word.
    function automatic logic [PC_W-1:0] pack_pc(input logic [LVL_W-1:0] m,
                                                input logic s, input logic t);
        logic [PC_W-1:0] w;
        w = '0;
        w[PC_MASK_LSB +: LVL_W] = m;
        w[PC_ST_BIT] = s;
        w[PC_TR_BIT] = t;
        return w;
    endfunction
endpackage

// File: rtl/irq_pick.sv
// Request selector: finds the highest priority strictly above the mask.
// Ties go to the lowest line index, and the non-maskable request overrides
// everything. Purely combinational; the clock exists only for its checks.
module irq_pick
    import irq_entry_pkg::*;
#(
    parameter int NREQ  = 8,
    parameter int VEC_W = $clog2(NREQ + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NREQ-1:0]         req,
    input  logic [NREQ*LVL_W-1:0]   prio,
    input  logic                    nmi,
    input  logic [LVL_W-1:0]        mask,
    output logic                    take,
    output logic [LVL_W-1:0]        take_lvl,
    output logic [VEC_W-1:0]        take_vec
);
    logic [LVL_W-1:0] prio_a [NREQ];
    logic [LVL_W-1:0] best;

    for (genvar g = 0; g < NREQ; g++) begin : g_unpack
        assign prio_a[g] = prio[g*LVL_W +: LVL_W];
    end

    // Scan lines in index order; strict compare keeps the lowest index on ties.
    always_comb begin
        take     = 1'b0;
        take_lvl = '0;
        take_vec = '0;
        best     = mask;
        for (int i = 0; i < NREQ; i++) begin
            if (req[i] && (prio_a[i] > best)) begin
                best     = prio_a[i];
                take     = 1'b1;
                take_lvl = prio_a[i];
                take_vec = VEC_W'(i);
            end
        end
        if (nmi) begin
            take     = 1'b1;
            take_lvl = LVL_MAX;
            take_vec = VEC_W'(NREQ);
        end
    end

    assert_pick_above_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !nmi) |-> (take_lvl > mask));
    assert_nmi_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |-> (take && take_lvl == LVL_MAX));
endmodule

// File: rtl/irq_seq.sv
// Entry/return sequencer. Owns mask level, interrupted flag and trace enable.
// It runs a two-write entry and a two-read return through the memory port.
// Assumes memory read data returns one cycle after mem_re, and that the core
// provides the frame pointer of the record being left when it pulses ret_req.
module irq_seq
    import irq_entry_pkg::*;
#(
    parameter int NREQ       = 8,
    parameter int VEC_W      = $clog2(NREQ + 1),
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter logic [ADDR_W-1:0] STACK_BASE = 32'h0000_0400
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take,
    input  logic [LVL_W-1:0]    take_lvl,
    input  logic [VEC_W-1:0]    take_vec,
    input  logic                ret_req,
    input  logic [ADDR_W-1:0]   cur_fp,
    input  logic [DATA_W-1:0]   ac_in,
    output logic                mem_we,
    output logic                mem_re,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                hstart,
    output logic [VEC_W-1:0]    hvec,
    output logic [ADDR_W-1:0]   new_fp,
    output logic [2:0]          ret_stat,
    output logic [LVL_W-1:0]    mask_lvl,
    output logic                intr_state,
    output logic                trace_en,
    output logic                ret_done,
    output logic [DATA_W-1:0]   ac_out,
    output logic                outer_exit
);
    seq_t               st;
    logic [LVL_W-1:0]   lvl_q, rd_mask;
    logic [VEC_W-1:0]   vec_q;
    logic [ADDR_W-1:0]  base_q, rfp_q;
    logic [DATA_W-1:0]  pc_q, ac_q;
    logic               rd_st, rd_tr;

    // Sequencer state, latched operands and control-state register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;  mask_lvl <= '0;  intr_state <= 1'b0;  trace_en <= 1'b0;
            lvl_q <= '0;  vec_q <= '0;  base_q <= '0;  rfp_q <= '0;
            pc_q <= '0;  ac_q <= '0;  ac_out <= '0;
            rd_mask <= '0;  rd_st <= 1'b0;  rd_tr <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (ret_req) begin
                        rfp_q <= cur_fp;
                        st    <= ST_RR0;
                    end else if (take) begin
                        lvl_q  <= take_lvl;
                        vec_q  <= take_vec;
                        base_q <= intr_state ? cur_fp : STACK_BASE;
                        pc_q   <= DATA_W'(pack_pc(mask_lvl, intr_state, trace_en));
                        ac_q   <= ac_in;
                        st     <= ST_EW0;
                    end
                end
                ST_EW0:   st <= ST_EW1;
                ST_EW1: begin
                    mask_lvl   <= lvl_q;
                    intr_state <= 1'b1;
                    trace_en   <= 1'b0;
                    st         <= ST_EDONE;
                end
                ST_EDONE: st <= ST_IDLE;
                ST_RR0:   st <= ST_RR1;
                ST_RR1: begin
                    rd_mask <= mem_rdata[PC_MASK_LSB +: LVL_W];
                    rd_st   <= mem_rdata[PC_ST_BIT];
                    rd_tr   <= mem_rdata[PC_TR_BIT];
                    st      <= ST_RR2;
                end
                ST_RR2: begin
                    ac_out     <= mem_rdata;
                    mask_lvl   <= rd_mask;
                    intr_state <= rd_st;
                    trace_en   <= rd_tr;
                    st         <= ST_RDONE;
                end
                default:  st <= ST_IDLE;
            endcase
        end
    end

    // Memory strobes, address and data for the record traffic.
    always_comb begin
        mem_we    = (st == ST_EW0) || (st == ST_EW1);
        mem_re    = (st == ST_RR0) || (st == ST_RR1);
        mem_addr  = '0;
        mem_wdata = '0;
        case (st)
            ST_EW0: begin mem_addr = base_q;                 mem_wdata = pc_q; end
            ST_EW1: begin mem_addr = base_q + ADDR_W'(4);    mem_wdata = ac_q; end
            ST_RR0:       mem_addr = rfp_q - ADDR_W'(16);
            ST_RR1:       mem_addr = rfp_q - ADDR_W'(12);
            default: ;
        endcase
    end

    // Hand-off signals to the core.
    assign hstart     = (st == ST_EDONE);
    assign hvec       = vec_q;
    assign new_fp     = base_q + ADDR_W'(16);
    assign ret_stat   = hstart ? RS_INTR : 3'b000;
    assign ret_done   = (st == ST_RDONE);
    assign outer_exit = ret_done && !intr_state;

    assert_mem_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
    assert_entry_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hstart |-> (intr_state && !trace_en));
    assert_record_stride_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(4)));
    assert_new_fp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hstart |-> (new_fp == $past(mem_addr) + ADDR_W'(12)));
    assert_outer_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        outer_exit |-> (ret_done && !intr_state));
endmodule

// File: rtl/irq_entry_ctrl.sv
// Top of the nested priority interrupt entry controller: the request
// selector feeds the entry/return sequencer, which owns the control state.
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int NREQ       = 8,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter logic [ADDR_W-1:0] STACK_BASE = 32'h0000_0400,
    localparam int VEC_W     = $clog2(NREQ + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NREQ-1:0]         irq_req,
    input  logic [NREQ*LVL_W-1:0]   irq_prio,
    input  logic                    nmi_req,
    input  logic                    ret_req,
    input  logic [ADDR_W-1:0]       cur_fp,
    input  logic [DATA_W-1:0]       ac_in,
    output logic                    mem_we,
    output logic                    mem_re,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic                    hstart,
    output logic [VEC_W-1:0]        hvec,
    output logic [ADDR_W-1:0]       new_fp,
    output logic [2:0]              ret_stat,
    output logic [LVL_W-1:0]        mask_lvl,
    output logic                    intr_state,
    output logic                    trace_en,
    output logic                    ret_done,
    output logic [DATA_W-1:0]       ac_out,
    output logic                    outer_exit
);
    logic               take;
    logic [LVL_W-1:0]   take_lvl;
    logic [VEC_W-1:0]   take_vec;

    irq_pick #(.NREQ(NREQ), .VEC_W(VEC_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .req(irq_req), .prio(irq_prio), .nmi(nmi_req),
        .mask(mask_lvl), .take(take), .take_lvl(take_lvl), .take_vec(take_vec)
    );

    irq_seq #(.NREQ(NREQ), .VEC_W(VEC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
              .STACK_BASE(STACK_BASE)) u_seq (
        .clk(clk), .rst_n(rst_n), .take(take), .take_lvl(take_lvl), .take_vec(take_vec),
        .ret_req(ret_req), .cur_fp(cur_fp), .ac_in(ac_in),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .hstart(hstart), .hvec(hvec), .new_fp(new_fp),
        .ret_stat(ret_stat), .mask_lvl(mask_lvl), .intr_state(intr_state),
        .trace_en(trace_en), .ret_done(ret_done), .ac_out(ac_out), .outer_exit(outer_exit)
    );
endmodule

// File: tb/irq_entry_ctrl_test.sv
// Self-checking bench: directed corner cases plus seeded random nesting,
// against a reference model of mask, flag, trace and frame stack.
module irq_entry_ctrl_test;
    localparam int NREQ = 8;
    localparam logic [31:0] SB = 32'h0000_0400;

    logic clk = 0, rst_n = 0;
    logic [NREQ-1:0] irq_req = '0;
    logic [NREQ*5-1:0] irq_prio = '0;
    logic nmi_req = 0, ret_req = 0;
    logic [31:0] cur_fp = '0, ac_in = '0, mem_addr, mem_wdata, mem_rdata, new_fp, ac_out;
    logic mem_we, mem_re, hstart, intr_state, trace_en, ret_done, outer_exit;
    logic [3:0] hvec;
    logic [2:0] ret_stat;
    logic [4:0] mask_lvl;

    irq_entry_ctrl #(.NREQ(NREQ), .STACK_BASE(SB)) uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_prio(irq_prio), .nmi_req(nmi_req),
        .ret_req(ret_req), .cur_fp(cur_fp), .ac_in(ac_in), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .hstart(hstart),
        .hvec(hvec), .new_fp(new_fp), .ret_stat(ret_stat), .mask_lvl(mask_lvl),
        .intr_state(intr_state), .trace_en(trace_en), .ret_done(ret_done), .ac_out(ac_out),
        .outer_exit(outer_exit)
    );

    always #4 clk = ~clk;

    logic [31:0] mem [0:1023];
    // Memory model with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        mem_rdata <= mem_re ? mem[mem_addr[11:2]] : 32'h0;
    end

    int checks = 0, errors = 0;
    bit done = 0;
    logic [4:0] m_mask = 0;
    logic m_state = 0, m_trace = 0;
    int depth = 0;
    logic [31:0] fp_stk [0:15];
    logic [31:0] sv_ac [0:15];
    logic [4:0] sv_mask [0:15];
    logic sv_st [0:15];
    logic sv_tr [0:15];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pcw(input logic [4:0] m, input logic s, input logic t);
        return {11'b0, m, 14'b0, s, t};
    endfunction

    // Reference selection: walk levels downward, lines upward.
    function automatic int pick_exp(input logic [NREQ-1:0] r, input logic [NREQ*5-1:0] p,
                                    input logic n, input logic [4:0] m);
        if (n) return NREQ;
        for (int l = 31; l > int'(m); l--)
            for (int i = 0; i < NREQ; i++)
                if (r[i] && int'(p[i*5 +: 5]) == l) return i;
        return -1;
    endfunction

    task automatic enter(input logic [NREQ-1:0] r, input logic [NREQ*5-1:0] p,
                         input logic n, input logic [31:0] ac, input bit poke_ret);
        int v, first, wes, res;
        logic [31:0] base, g_fp;
        logic [3:0] g_vec;
        logic [4:0] g_mask, lvl;
        logic g_st, g_tr;
        logic [2:0] g_rs;
        v = pick_exp(r, p, n, m_mask);
        base = m_state ? fp_stk[depth-1] : SB;
        @(negedge clk);
        irq_req = r; irq_prio = p; nmi_req = n; ac_in = ac;
        cur_fp = m_state ? fp_stk[depth-1] : 32'h0000_0BC0;
        first = -1; wes = 0; res = 0;
        g_fp = 0; g_vec = 0; g_mask = 0; g_st = 0; g_tr = 1; g_rs = 0;
        for (int c = 1; c <= 6; c++) begin
            @(negedge clk);
            if (poke_ret) ret_req = (c == 1);
            if (mem_we) wes++;
            if (mem_re) res++;
            if (hstart && first < 0) begin
                first = c; g_fp = new_fp; g_vec = hvec; g_mask = mask_lvl;
                g_st = intr_state; g_tr = trace_en; g_rs = ret_stat;
                irq_req = '0; nmi_req = 0;
            end
        end
        irq_req = '0; nmi_req = 0; ret_req = 0;
        if (v < 0) begin
            check("R2 ignored request started", first, -1);
            check("R2 ignored request wrote", wes, 0);
            check("R2 mask unchanged", {27'b0, mask_lvl}, {27'b0, m_mask});
        end else begin
            lvl = n ? 5'd31 : p[v*5 +: 5];
            check("R7 start cycle", first, 3);
            check(n ? "R4 vector" : "R3 vector", {28'b0, g_vec}, v);
            check("R7 mask at start", {27'b0, g_mask}, {27'b0, lvl});
            check("R7 flag/trace at start", {30'b0, g_st, g_tr}, 32'h2);
            check("R7 return status", {29'b0, g_rs}, 32'h7);
            check("R5 new frame pointer", g_fp, base + 32'd16);
            check("R6 two writes", wes, 2);
            check("R10 no reads in entry", res, 0);
            check("R6 saved control word", mem[base[11:2]], pcw(m_mask, m_state, m_trace));
            check("R6 saved arith word", mem[base[11:2] + 10'd1], ac);
            sv_mask[depth] = m_mask; sv_st[depth] = m_state; sv_tr[depth] = m_trace;
            sv_ac[depth] = ac; fp_stk[depth] = base + 32'd16; depth++;
            m_mask = lvl; m_state = 1; m_trace = 0;
        end
    endtask

    task automatic ret_seq(input logic [31:0] fp, input logic [4:0] em, input logic es,
                           input logic et, input logic [31:0] eac, input bit with_req);
        int first, wes, res;
        logic [31:0] g_ac;
        logic [4:0] g_mask;
        logic g_st, g_tr, g_oe;
        @(negedge clk);
        ret_req = 1; cur_fp = fp;
        if (with_req) begin irq_req = 8'h80; irq_prio = {5'd31, 35'd0}; end
        first = -1; wes = 0; res = 0; g_ac = 0; g_mask = 0; g_st = 0; g_tr = 0; g_oe = 0;
        for (int c = 1; c <= 6; c++) begin
            @(negedge clk);
            ret_req = 0;
            if (mem_we) wes++;
            if (mem_re) res++;
            if (ret_done && first < 0) begin
                first = c; g_ac = ac_out; g_mask = mask_lvl; g_st = intr_state;
                g_tr = trace_en; g_oe = outer_exit; irq_req = '0;
            end
        end
        irq_req = '0;
        check("R8 return done cycle", first, 4);
        check("R8 two reads", res, 2);
        check("R10 no writes in return", wes, 0);
        check("R8 arith word", g_ac, eac);
        check("R8 restored mask", {27'b0, g_mask}, {27'b0, em});
        check("R8 restored flag/trace", {30'b0, g_st, g_tr}, {30'b0, es, et});
        check("R9 outermost exit", {31'b0, g_oe}, {31'b0, !es});
        m_mask = em; m_state = es; m_trace = et;
    endtask

    task automatic pop(input bit with_req);
        depth--;
        ret_seq(fp_stk[depth], sv_mask[depth], sv_st[depth], sv_tr[depth], sv_ac[depth], with_req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        check("R1 mask", {27'b0, mask_lvl}, 0);
        check("R1 flag/trace", {30'b0, intr_state, trace_en}, 0);
        check("R1 pulses and strobes", {28'b0, hstart, ret_done, mem_we, mem_re}, 0);
        // R2: priority 0 at mask 0
        enter(8'h01, '0, 0, 32'h1, 0);
        // Prepared record: restore trace 1, mask 3, flag 0 at depth 0 (R8, R9)
        mem[(32'h300) >> 2] = pcw(5'd3, 1'b0, 1'b1);
        mem[(32'h304) >> 2] = 32'h0000_ABCD;
        ret_seq(32'h310, 5'd3, 1'b0, 1'b1, 32'h0000_ABCD, 0);
        // R3: tie at level 7 on lines 2 and 5, line 1 lower; saved word keeps trace
        enter(8'h26, {10'd0, 5'd7, 10'd0, 5'd7, 5'd3, 5'd0}, 0, 32'h1111, 0);
        // R2: equal to mask is ignored
        enter(8'h08, {20'd0, 5'd7, 15'd0}, 0, 32'h2222, 0);
        // R5: nested at level 8, base is previous frame; R10 return poked mid-entry
        enter(8'h40, {5'd0, 5'd8, 30'd0}, 0, 32'h3333, 1);
        // R4: NMI beats a level-31 line, then level 31 ignored, then NMI nests
        enter(8'h01, {35'd0, 5'd31}, 1, 32'h4444, 0);
        enter(8'h01, {35'd0, 5'd31}, 0, 32'h5555, 0);
        enter(8'h00, '0, 1, 32'h6666, 0);
        pop(0); pop(0);
        // R10: return offered together with a request is served first
        pop(1);
        pop(0);
        // Random nesting
        for (int it = 0; it < 80; it++) begin
            if (depth == 0 || (depth < 6 && ($urandom % 3) != 0))
                enter(NREQ'($urandom), {$urandom, $urandom} & 40'hFF_FFFF_FFFF,
                      ($urandom % 8) == 0, $urandom, 0);
            else
                pop(0);
        end
        while (depth > 0) pop(0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule